// File: doc/BRIEF.md
# PCIe Root-Port Bring-Up Sequencer

This block takes a PCIe root-port controller from a cold, fully reset condition to the point where link training may begin. It is a timer-driven state machine. After a start pulse it asserts the fundamental resets, powers the slot, and holds the resets for a programmable settling time. It then releases the controller and the board resets, enables the auxiliary clock, and places the PHY in a held state before it lets the controller out of power-up reset.

While the PHY is still held, the sequencer hands control to a separate PHY register-programming engine through a start pulse and a done input. Once the engine reports completion, the sequencer gates the auxiliary clock off, drops the PHY hold, and restores the clock. Gating the clock around the hold release keeps the PHY from seeing a clock edge while its hold changes state. Finally the sequencer selects root-complex mode on the device-type output and raises ready.

A shutdown request from any point pulls both fundamental resets low again, controller first, and then returns every output to its reset value, so that a later start begins from a clean state.

Top module: `pcie_bringup_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, the outputs are: slot power 0, both fundamental-reset outputs 0, auxiliary clock 0, PHY hold 0, power-up reset 0, device type 0, programming start 0, ready 0, and `state_o` 0 (idle).
- R2: A start pulse sampled in idle moves `state_o` to 1 with the controller reset low on the next cycle. On the cycle after that, `state_o` is 2 with the board reset low. On the third cycle, `state_o` is 3 and slot power rises.
- R3: Slot power stays high for exactly `PWR_WAIT_CYCLES` cycles, with `state_o` at 3, before the controller reset output rises (`state_o` 4). The board reset output rises one cycle later (`state_o` 5).
- R4: On the three cycles after the board reset is released, the following happen in order: the auxiliary clock turns on (`state_o` 6), the PHY hold rises (`state_o` 7), and the power-up reset is released (`state_o` 8).
- R5: On the next cycle, the programming start output is high for exactly one cycle, with the hold, clock and power-up release all high (`state_o` 9). The sequencer then stays in state 9 for as long as the done input stays low.
- R6: Done sampled high in state 9 produces this order: the auxiliary clock goes off on the next cycle (`state_o` 10), the PHY hold clears on the cycle after (`state_o` 11), and the clock comes back on the cycle after that (`state_o` 12).
- R7: On the next cycle the device-type output becomes 4, meaning root complex (`state_o` 13). Ready rises one cycle later (`state_o` 14), and the block then stays in state 14.
- R8: A shutdown request sampled in any state other than 15 or 16 drives the controller reset low on the next cycle (`state_o` 15). The board reset goes low on the cycle after (`state_o` 16). On the third cycle every output returns to its R1 value. Shutdown takes priority over start and done.
- R9: A start pulse sampled in any state other than idle has no effect on the state or on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin the bring-up sequence (acted on only in idle) |
| shutdown_i | input | 1 | Drop the fundamental resets and return to idle |
| prog_done_i | input | 1 | PHY programming engine has finished |
| slot_pwr_en_o | output | 1 | Slot power enable |
| ctrl_perst_n_o | output | 1 | Controller fundamental reset, active low |
| board_perst_n_o | output | 1 | Board fundamental reset, active low |
| aux_clk_en_o | output | 1 | Auxiliary clock enable |
| phy_hold_o | output | 1 | Hold the PHY and link state machine in reset |
| pwrup_rst_n_o | output | 1 | Power-up reset, active low |
| dev_type_o | output | DEV_TYPE_W | Device-type selection (4 = root complex) |
| prog_start_o | output | 1 | One-cycle start pulse to the PHY programming engine |
| ready_o | output | 1 | Controller ready for link training |
| state_o | output | 5 | Current sequencer state (debug) |

## Verification
Some properties are checked by the assertions on every cycle. Slot power must have been high for at least the settling count before the controller reset rises. The board reset never rises before the controller reset. The programming pulse lasts one cycle and occurs only with hold, clock and power-up release all high. The hold only falls while the clock is gated. Ready implies root-complex mode. A shutdown is followed at once by the controller reset going low.

The exact cycle on which each output moves needs the bench's scripted scenarios. These include a full bring-up, a long programming wait, and start pulses sent while busy. They also include shutdowns during the settling wait, during programming (with done arriving at the same time), and after ready.

// File: rtl/pcie_bringup_pkg.sv
package pcie_bringup_pkg;

  localparam int STATE_W = 5;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE      = 5'd0,
    ST_CTRL_RST  = 5'd1,
    ST_BRD_RST   = 5'd2,
    ST_PWR_WAIT  = 5'd3,
    ST_CTRL_REL  = 5'd4,
    ST_BRD_REL   = 5'd5,
    ST_AUX_ON    = 5'd6,
    ST_HOLD      = 5'd7,
    ST_PWRUP     = 5'd8,
    ST_PROG      = 5'd9,
    ST_AUX_OFF   = 5'd10,
    ST_UNHOLD    = 5'd11,
    ST_AUX_BACK  = 5'd12,
    ST_TYPE      = 5'd13,
    ST_READY     = 5'd14,
    ST_DOWN_CTRL = 5'd15,
    ST_DOWN_BRD  = 5'd16
  } seq_state_e;

  typedef struct packed {
    logic slot_pwr;
    logic ctrl_perst_n;
    logic brd_perst_n;
    logic aux_clk;
    logic phy_hold;
    logic pwrup_rst_n;
    logic prog_start;
    logic ready;
  } ctl_t;

endpackage

// File: rtl/bringup_timer.sv
module bringup_timer #(
  parameter int CYCLES = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expired_o = run_i && (cnt_q == LAST);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run_i) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != LAST) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bringup_fsm.sv
module bringup_fsm
  import pcie_bringup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       shutdown_i,
  input  logic       prog_done_i,
  input  logic       wait_done_i,
  output seq_state_e state_q,
  output seq_state_e state_d
);
  logic in_down;
  assign in_down = (state_q == ST_DOWN_CTRL) || (state_q == ST_DOWN_BRD);

  always_comb begin
    state_d = state_q;
    if (shutdown_i && !in_down) begin
      state_d = ST_DOWN_CTRL;
    end else begin
      unique case (state_q)
        ST_IDLE:      if (start_i) state_d = ST_CTRL_RST;
        ST_CTRL_RST:  state_d = ST_BRD_RST;
        ST_BRD_RST:   state_d = ST_PWR_WAIT;
        ST_PWR_WAIT:  if (wait_done_i) state_d = ST_CTRL_REL;
        ST_CTRL_REL:  state_d = ST_BRD_REL;
        ST_BRD_REL:   state_d = ST_AUX_ON;
        ST_AUX_ON:    state_d = ST_HOLD;
        ST_HOLD:      state_d = ST_PWRUP;
        ST_PWRUP:     state_d = ST_PROG;
        ST_PROG:      if (prog_done_i) state_d = ST_AUX_OFF;
        ST_AUX_OFF:   state_d = ST_UNHOLD;
        ST_UNHOLD:    state_d = ST_AUX_BACK;
        ST_AUX_BACK:  state_d = ST_TYPE;
        ST_TYPE:      state_d = ST_READY;
        ST_READY:     state_d = ST_READY;
        ST_DOWN_CTRL: state_d = ST_DOWN_BRD;
        ST_DOWN_BRD:  state_d = ST_IDLE;
        default:      state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  state_q <= ST_IDLE;
    else if (state_d != state_q) state_q <= state_d;
  end
endmodule

// File: rtl/bringup_outreg.sv
module bringup_outreg
  import pcie_bringup_pkg::*;
#(
  parameter int DEV_TYPE_W = 4,
  parameter int RC_TYPE    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  seq_state_e            state_q,
  input  seq_state_e            state_d,
  output ctl_t                  ctl_q,
  output logic [DEV_TYPE_W-1:0] dev_type_q
);
  ctl_t                  ctl_d;
  logic [DEV_TYPE_W-1:0] dev_type_d;
  logic                  upd_en;

  // Each state applies its action once, on the edge that enters it.
  always_comb begin
    ctl_d            = ctl_q;
    ctl_d.prog_start = 1'b0;
    dev_type_d       = dev_type_q;
    if (state_d != state_q) begin
      unique case (state_d)
        ST_IDLE:      begin ctl_d = '0; dev_type_d = '0; end
        ST_CTRL_RST:  ctl_d.ctrl_perst_n = 1'b0;
        ST_BRD_RST:   ctl_d.brd_perst_n  = 1'b0;
        ST_PWR_WAIT:  ctl_d.slot_pwr     = 1'b1;
        ST_CTRL_REL:  ctl_d.ctrl_perst_n = 1'b1;
        ST_BRD_REL:   ctl_d.brd_perst_n  = 1'b1;
        ST_AUX_ON:    ctl_d.aux_clk      = 1'b1;
        ST_HOLD:      ctl_d.phy_hold     = 1'b1;
        ST_PWRUP:     ctl_d.pwrup_rst_n  = 1'b1;
        ST_PROG:      ctl_d.prog_start   = 1'b1;
        ST_AUX_OFF:   ctl_d.aux_clk      = 1'b0;
        ST_UNHOLD:    ctl_d.phy_hold     = 1'b0;
        ST_AUX_BACK:  ctl_d.aux_clk      = 1'b1;
        ST_TYPE:      dev_type_d         = DEV_TYPE_W'(RC_TYPE);
        ST_READY:     ctl_d.ready        = 1'b1;
        ST_DOWN_CTRL: ctl_d.ctrl_perst_n = 1'b0;
        ST_DOWN_BRD:  ctl_d.brd_perst_n  = 1'b0;
        default:      ctl_d = '0;
      endcase
    end
  end

  assign upd_en = (state_d != state_q) || ctl_q.prog_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q      <= '0;
      dev_type_q <= '0;
    end else if (upd_en) begin
      ctl_q      <= ctl_d;
      dev_type_q <= dev_type_d;
    end
  end
endmodule

// File: rtl/pcie_bringup_seq.sv
module pcie_bringup_seq
  import pcie_bringup_pkg::*;
#(
  parameter int PWR_WAIT_CYCLES = 10_000_000,
  parameter int DEV_TYPE_W      = 4,
  parameter int RC_TYPE         = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  shutdown_i,
  input  logic                  prog_done_i,
  output logic                  slot_pwr_en_o,
  output logic                  ctrl_perst_n_o,
  output logic                  board_perst_n_o,
  output logic                  aux_clk_en_o,
  output logic                  phy_hold_o,
  output logic                  pwrup_rst_n_o,
  output logic [DEV_TYPE_W-1:0] dev_type_o,
  output logic                  prog_start_o,
  output logic                  ready_o,
  output logic [STATE_W-1:0]    state_o
);
  seq_state_e state_q, state_d;
  ctl_t       ctl_q;
  logic       wait_done;

  bringup_timer #(.CYCLES(PWR_WAIT_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (state_q == ST_PWR_WAIT),
    .expired_o (wait_done)
  );

  bringup_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .shutdown_i  (shutdown_i),
    .prog_done_i (prog_done_i),
    .wait_done_i (wait_done),
    .state_q     (state_q),
    .state_d     (state_d)
  );

  bringup_outreg #(.DEV_TYPE_W(DEV_TYPE_W), .RC_TYPE(RC_TYPE)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .state_d    (state_d),
    .ctl_q      (ctl_q),
    .dev_type_q (dev_type_o)
  );

  assign slot_pwr_en_o   = ctl_q.slot_pwr;
  assign ctrl_perst_n_o  = ctl_q.ctrl_perst_n;
  assign board_perst_n_o = ctl_q.brd_perst_n;
  assign aux_clk_en_o    = ctl_q.aux_clk;
  assign phy_hold_o      = ctl_q.phy_hold;
  assign pwrup_rst_n_o   = ctl_q.pwrup_rst_n;
  assign prog_start_o    = ctl_q.prog_start;
  assign ready_o         = ctl_q.ready;
  assign state_o         = state_q;
endmodule

// File: rtl/pcie_bringup_chk.sv
module pcie_bringup_chk #(
  parameter int PWR_WAIT_CYCLES = 10_000_000,
  parameter int DEV_TYPE_W      = 4,
  parameter int RC_TYPE         = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start_i,
  input logic                  shutdown_i,
  input logic                  slot_pwr_en_o,
  input logic                  ctrl_perst_n_o,
  input logic                  board_perst_n_o,
  input logic                  aux_clk_en_o,
  input logic                  phy_hold_o,
  input logic                  pwrup_rst_n_o,
  input logic [DEV_TYPE_W-1:0] dev_type_o,
  input logic                  prog_start_o,
  input logic                  ready_o,
  input logic [4:0]            state_o
);
  localparam int PW = $clog2(PWR_WAIT_CYCLES + 1) + 1;
  localparam logic [PW-1:0] PMAX = {PW{1'b1}};

  logic [PW-1:0] pwr_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pwr_cnt <= '0;
    else if (!slot_pwr_en_o) pwr_cnt <= '0;
    else if (pwr_cnt != PMAX) pwr_cnt <= pwr_cnt + 1'b1;
  end

  AST_PWR_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_perst_n_o) |-> (pwr_cnt >= PW'(PWR_WAIT_CYCLES))); // R3
  AST_BRD_AFTER_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(board_perst_n_o) |-> (ctrl_perst_n_o && $past(ctrl_perst_n_o))); // R3
  AST_PWRUP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwrup_rst_n_o) |-> (phy_hold_o && aux_clk_en_o)); // R4
  AST_PROG_COND: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start_o |-> (phy_hold_o && pwrup_rst_n_o && aux_clk_en_o)); // R5
  AST_PROG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start_o |=> !prog_start_o); // R5
  AST_UNHOLD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phy_hold_o) |-> !aux_clk_en_o); // R6
  AST_READY_RC: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (dev_type_o == DEV_TYPE_W'(RC_TYPE))); // R7
  AST_SHUT_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_i |=> !ctrl_perst_n_o); // R8
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !shutdown_i && state_o != 5'd0) |=> (state_o != 5'd1)); // R9
endmodule

bind pcie_bringup_seq pcie_bringup_chk #(
  .PWR_WAIT_CYCLES (PWR_WAIT_CYCLES),
  .DEV_TYPE_W      (DEV_TYPE_W),
  .RC_TYPE         (RC_TYPE)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .start_i         (start_i),
  .shutdown_i      (shutdown_i),
  .slot_pwr_en_o   (slot_pwr_en_o),
  .ctrl_perst_n_o  (ctrl_perst_n_o),
  .board_perst_n_o (board_perst_n_o),
  .aux_clk_en_o    (aux_clk_en_o),
  .phy_hold_o      (phy_hold_o),
  .pwrup_rst_n_o   (pwrup_rst_n_o),
  .dev_type_o      (dev_type_o),
  .prog_start_o    (prog_start_o),
  .ready_o         (ready_o),
  .state_o         (state_o)
);

// File: tb/pcie_bringup_seq_test.sv
`timescale 1ns/1ps
module pcie_bringup_seq_test;
  localparam int WAIT_N = 4;

  typedef struct packed {
    logic [4:0] st;
    logic       pwr, ctrl, brd, aux, hold, pwrup;
    logic [3:0] dt;
    logic       ps, rdy;
  } obs_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, shutdown_i = 1'b0, prog_done_i = 1'b0;
  logic slot_pwr_en_o, ctrl_perst_n_o, board_perst_n_o, aux_clk_en_o;
  logic phy_hold_o, pwrup_rst_n_o, prog_start_o, ready_o;
  logic [3:0] dev_type_o;
  logic [4:0] state_o;

  int checks = 0;
  int errors = 0;
  obs_t  e;
  obs_t  exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  pcie_bringup_seq #(.PWR_WAIT_CYCLES(WAIT_N), .DEV_TYPE_W(4), .RC_TYPE(4)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .shutdown_i(shutdown_i),
    .prog_done_i(prog_done_i), .slot_pwr_en_o(slot_pwr_en_o),
    .ctrl_perst_n_o(ctrl_perst_n_o), .board_perst_n_o(board_perst_n_o),
    .aux_clk_en_o(aux_clk_en_o), .phy_hold_o(phy_hold_o),
    .pwrup_rst_n_o(pwrup_rst_n_o), .dev_type_o(dev_type_o),
    .prog_start_o(prog_start_o), .ready_o(ready_o), .state_o(state_o)
  );

  function automatic obs_t observe();
    obs_t o;
    o.st = state_o; o.pwr = slot_pwr_en_o; o.ctrl = ctrl_perst_n_o;
    o.brd = board_perst_n_o; o.aux = aux_clk_en_o; o.hold = phy_hold_o;
    o.pwrup = pwrup_rst_n_o; o.dt = dev_type_o; o.ps = prog_start_o;
    o.rdy = ready_o;
    return o;
  endfunction

  // Driver: apply inputs for one cycle and queue the outputs expected after it.
  task automatic tick(input logic st, input logic sh, input logic dn, input string tag);
    @(negedge clk);
    start_i = st; shutdown_i = sh; prog_done_i = dn;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare each queued expectation just after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        obs_t  x;
        obs_t  a;
        string t;
        x = exp_q.pop_front();
        t = tag_q.pop_front();
        a = observe();
        checks++;
        if (a !== x) begin
          errors++;
          $display("FAIL %s actual %h expected %h", t, a, x);
        end
      end
    end
  end

  task automatic to_prog();
    e.st = 5'd1;                   tick(1, 0, 0, "R2");
    e.st = 5'd2;                   tick(0, 0, 0, "R2");
    e.st = 5'd3; e.pwr = 1'b1;     tick(0, 0, 0, "R2");
    for (int i = 1; i < WAIT_N; i++) tick((i == 2), 0, 0, "R3_R9");
    e.st = 5'd4; e.ctrl = 1'b1;    tick(0, 0, 0, "R3");
    e.st = 5'd5; e.brd = 1'b1;     tick(0, 0, 0, "R3");
    e.st = 5'd6; e.aux = 1'b1;     tick(0, 0, 0, "R4");
    e.st = 5'd7; e.hold = 1'b1;    tick(0, 0, 0, "R4");
    e.st = 5'd8; e.pwrup = 1'b1;   tick(0, 0, 0, "R4");
    e.st = 5'd9; e.ps = 1'b1;      tick(0, 0, 0, "R5");
    e.ps = 1'b0;
  endtask

  task automatic shut_seq(input logic dn);
    e.st = 5'd15; e.ctrl = 1'b0; e.ps = 1'b0; tick(0, 1, dn, "R8");
    e.st = 5'd16; e.brd = 1'b0;  tick(0, 0, 0, "R8");
    e = '0;                      tick(0, 0, 0, "R8");
  endtask

  initial begin
    e = '0;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (observe() !== obs_t'('0)) begin
      errors++;
      $display("FAIL R1 actual %h expected %h", observe(), obs_t'('0));
    end
    @(negedge clk);
    rst_n = 1'b1;
    tick(0, 0, 0, "R1");

    // Full bring-up with a long programming wait
    to_prog();
    repeat (5) tick(0, 0, 0, "R5");
    e.st = 5'd10; e.aux = 1'b0;  tick(0, 0, 1, "R6");
    e.st = 5'd11; e.hold = 1'b0; tick(0, 0, 0, "R6");
    e.st = 5'd12; e.aux = 1'b1;  tick(0, 0, 0, "R6");
    e.st = 5'd13; e.dt = 4'd4;   tick(0, 0, 0, "R7");
    e.st = 5'd14; e.rdy = 1'b1;  tick(0, 0, 0, "R7");
    tick(1, 0, 0, "R9");
    tick(0, 0, 0, "R7");
    shut_seq(1'b0);

    // Shutdown during programming, done arriving together
    to_prog();
    tick(0, 0, 0, "R5");
    shut_seq(1'b1);

    // Shutdown during the power settling wait, with start also asserted
    e.st = 5'd1;               tick(1, 0, 0, "R2");
    e.st = 5'd2;               tick(0, 0, 0, "R2");
    e.st = 5'd3; e.pwr = 1'b1; tick(0, 0, 0, "R2");
    e.st = 5'd15;              tick(1, 1, 0, "R8");
    e.st = 5'd16;              tick(1, 0, 0, "R8_R9");
    e = '0;                    tick(0, 0, 0, "R8");
    tick(0, 0, 0, "R1");

    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule